// File: doc/BRIEF.md
# Ethernet Frame Length and Inter-Frame Gap Monitor

This block watches a byte-wide receive or transmit data path, one that has a data-valid strobe, and gives a verdict on every frame that passes. It finds the start delimiter byte (0xD5). It then counts the bytes up to the clock where data-valid drops. From that count it derives the payload size, and it classifies the frame as a runt, an oversize frame or a jumbo frame. Between frames it counts the clocks in which data-valid is low. It flags a frame that started before the minimum gap of 96 bit times had elapsed.

The monitor runs on one fixed-rate byte clock. A byte-enable input qualifies the clocks that carry a real byte, so a slower link can feed the same clock. The gap limit is held in bit times and converted to clocks from a link-speed code: 12 clocks at 1000 Mb/s, 120 at 100 Mb/s and 1200 at 10 Mb/s. Each frame produces a one-clock status strobe carrying its length, its payload size and its flags. Three saturating counters accumulate the runt, oversize and short-gap events for the whole run.

Top module: `frame_gap_monitor`

## Requirements
- R1: While reset is active and right after it, `statusValid` and every status flag are 0 and all three error counters read 0.
- R2: The frame length is the number of bytes accepted after the first 0xD5 byte of a data-valid burst, up to the clock where data-valid falls. The 0xD5 byte and the bytes before it are not counted. The length is reported with `statusValid` high for exactly one clock. That clock is the one following the first clock edge that samples data-valid low.
- R3: `statusPayload` equals the length minus 18, or 0 when the length is below 18.
- R4: A frame whose length is below 64 is flagged runt. A burst that never carries 0xD5 reports length 0 and is a runt.
- R5: With `jumboEn` low, a payload above 1500 is flagged oversize, and a payload of exactly 1500 is not.
- R6: With `jumboEn` high, a payload from 1501 to `JUMBO_MAX` (default 9000) raises the jumbo flag and not oversize. A payload above `JUMBO_MAX` is oversize. `jumboEn` is taken at the clock where data-valid falls.
- R7: The gap is the number of clock edges that sample data-valid low between two frames. It is short when it is below 12 times the clocks per byte. The link-speed code gives the clocks per byte: 00 is 100, 01 is 10, and 10 or 11 is 1. The code is taken at the edge where data-valid rises. The short-gap flag is reported on the status of the frame that follows the gap.
- R8: The first frame after reset is never flagged short-gap.
- R9: Each counter (runt, oversize, short-gap) rises by one in the clock after a status strobe that carries its flag. It holds at all ones rather than wrapping.
- R10: `clrCounters` zeroes all three counters at the next clock edge. It wins over an increment in the same cycle.
- R11: Clocks with `rxByteEn` low are neither counted nor examined for the start delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-rate byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxDv | input | 1 | Data-valid of the observed path |
| rxByteEn | input | 1 | Marks clocks that carry a real byte |
| rxData | input | 8 | Observed byte |
| linkSpeed | input | 2 | 00 = 10 Mb/s, 01 = 100 Mb/s, 10/11 = 1000 Mb/s |
| jumboEn | input | 1 | Raises the payload limit to JUMBO_MAX |
| clrCounters | input | 1 | Synchronous clear of the error counters |
| statusValid | output | 1 | One-clock strobe per frame |
| statusLength | output | LEN_W | Counted frame length in bytes |
| statusPayload | output | LEN_W | Length minus 18, floored at 0 |
| statusRunt | output | 1 | Length below 64 |
| statusOversize | output | 1 | Payload above the active limit |
| statusJumbo | output | 1 | Payload within the jumbo range while jumbo mode is enabled |
| statusShortGap | output | 1 | Gap before this frame was too short |
| runtCount | output | CNT_W | Saturating runt count |
| oversizeCount | output | CNT_W | Saturating oversize count |
| shortGapCount | output | CNT_W | Saturating short-gap count |

## Verification
A counter clear and a counter increment can land in the same clock. This happens when `clrCounters` is raised during the very clock in which a status strobe carries a runt or short-gap flag. The bench provokes it by asserting the clear exactly while the strobe is high for a runt frame. It then judges the counters one clock later, and they must read 0, not 1. A second overlap is the gap decision and the frame verdict of the next frame: a short gap at the rise must survive to the status strobe alongside the length flags. The bench checks both fields on the same strobe at each speed's boundary gap.

// File: rtl/frmon_pkg.sv
package frmon_pkg;

  // Strobes handed from the control module to the datapath
  typedef struct packed {
    logic frameStart;  // edge samples data-valid rising
    logic frameEnd;    // edge samples data-valid falling
    logic byteInc;     // a counted frame byte is present
    logic idleInc;     // an idle clock is present
  } mon_strobe_t;

  typedef enum logic [1:0] {
    SPD_10M    = 2'b00,
    SPD_100M   = 2'b01,
    SPD_1G     = 2'b10,
    SPD_1G_ALT = 2'b11
  } link_speed_e;

  localparam logic [7:0] START_DELIM = 8'hD5;
  localparam int ERR_KINDS = 3;  // index 0 runt, 1 oversize, 2 short gap

endpackage

// File: rtl/frmon_ctrl.sv
module frmon_ctrl
  import frmon_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxDv,
  input  logic        rxByteEn,
  input  logic [7:0]  rxData,
  output mon_strobe_t strobe
);

  logic dvPrev;
  logic counting;

  always_comb begin
    strobe.frameStart = rxDv && !dvPrev;
    strobe.frameEnd   = !rxDv && dvPrev;
    strobe.byteInc    = rxDv && rxByteEn && counting;
    strobe.idleInc    = !rxDv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvPrev   <= 1'b0;
      counting <= 1'b0;
    end else begin
      dvPrev <= rxDv;
      if (!rxDv) begin
        counting <= 1'b0;
      end else if (!counting && rxByteEn && (rxData == START_DELIM)) begin
        counting <= 1'b1;
      end
    end
  end

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.frameEnd |=> !strobe.frameEnd); // R2

  AST_NO_COUNT_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.frameStart |-> !strobe.byteInc); // R2

endmodule

// File: rtl/frmon_datapath.sv
module frmon_datapath
  import frmon_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int JUMBO_MAX = 9000,
  parameter int GAP_BITS  = 96,
  parameter int CPB_100M  = 10,
  parameter int CPB_10M   = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mon_strobe_t      strobe,
  input  logic [1:0]       linkSpeed,
  input  logic             jumboEn,
  output logic             statusValid,
  output logic [LEN_W-1:0] statusLength,
  output logic [LEN_W-1:0] statusPayload,
  output logic             statusRunt,
  output logic             statusOversize,
  output logic             statusJumbo,
  output logic             statusShortGap
);

  localparam int GAP_BYTES = GAP_BITS / 8;
  localparam int THR_1G    = GAP_BYTES;
  localparam int THR_100M  = GAP_BYTES * CPB_100M;
  localparam int THR_10M   = GAP_BYTES * CPB_10M;
  localparam int IDLE_W    = $clog2(THR_10M + 1) + 1;

  localparam logic [LEN_W-1:0]  MIN_FRAME = LEN_W'(64);
  localparam logic [LEN_W-1:0]  OVERHEAD  = LEN_W'(18);
  localparam logic [LEN_W-1:0]  STD_MAX   = LEN_W'(1500);
  localparam logic [LEN_W-1:0]  JMB_MAX   = LEN_W'(JUMBO_MAX);
  localparam logic [LEN_W-1:0]  LEN_TOP   = '1;
  localparam logic [IDLE_W-1:0] IDLE_TOP  = '1;

  logic [LEN_W-1:0]  byteCount;
  logic [IDLE_W-1:0] idleCount;
  logic [IDLE_W-1:0] gapThreshold;
  logic              armed;
  logic              pendingShort;
  logic [LEN_W-1:0]  payloadNow;
  logic              overNow;
  logic              jumboNow;

  always_comb begin
    case (link_speed_e'(linkSpeed))
      SPD_10M:  gapThreshold = IDLE_W'(THR_10M);
      SPD_100M: gapThreshold = IDLE_W'(THR_100M);
      default:  gapThreshold = IDLE_W'(THR_1G);
    endcase
  end

  always_comb begin
    payloadNow = (byteCount >= OVERHEAD) ? (byteCount - OVERHEAD) : '0;
    overNow    = jumboEn ? (payloadNow > JMB_MAX) : (payloadNow > STD_MAX);
    jumboNow   = jumboEn && (payloadNow > STD_MAX) && !(payloadNow > JMB_MAX);
  end

  // Frame byte counter, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteCount <= '0;
    end else if (strobe.frameEnd) begin
      byteCount <= '0;
    end else if (strobe.byteInc && (byteCount != LEN_TOP)) begin
      byteCount <= byteCount + 1'b1;
    end
  end

  // Idle clock counter and gap decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCount    <= '0;
      armed        <= 1'b0;
      pendingShort <= 1'b0;
    end else begin
      if (strobe.frameEnd) begin
        idleCount <= IDLE_W'(1);
        armed     <= 1'b1;
      end else if (strobe.idleInc && (idleCount != IDLE_TOP)) begin
        idleCount <= idleCount + 1'b1;
      end
      if (strobe.frameStart) begin
        pendingShort <= armed && (idleCount < gapThreshold);
      end
    end
  end

  // Per-frame status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusValid    <= 1'b0;
      statusLength   <= '0;
      statusPayload  <= '0;
      statusRunt     <= 1'b0;
      statusOversize <= 1'b0;
      statusJumbo    <= 1'b0;
      statusShortGap <= 1'b0;
    end else begin
      statusValid <= strobe.frameEnd;
      if (strobe.frameEnd) begin
        statusLength   <= byteCount;
        statusPayload  <= payloadNow;
        statusRunt     <= byteCount < MIN_FRAME;
        statusOversize <= overNow;
        statusJumbo    <= jumboNow;
        statusShortGap <= pendingShort;
      end
    end
  end

  AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    statusValid |=> !statusValid); // R2

  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    statusValid |-> $onehot0({statusRunt, statusOversize, statusJumbo})); // R6

  AST_PAYLOAD_LE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    statusValid |-> (statusPayload <= statusLength)); // R3

endmodule

// File: rtl/frmon_sat_counter.sv
module frmon_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end

  AST_CNT_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (count == TOP)) |=> (count == TOP)); // R9

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R10

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count)); // R9

endmodule

// File: rtl/frame_gap_monitor.sv
module frame_gap_monitor
  import frmon_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 16,
  parameter int JUMBO_MAX = 9000,
  parameter int GAP_BITS  = 96,
  parameter int CPB_100M  = 10,
  parameter int CPB_10M   = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxDv,
  input  logic             rxByteEn,
  input  logic [7:0]       rxData,
  input  logic [1:0]       linkSpeed,
  input  logic             jumboEn,
  input  logic             clrCounters,
  output logic             statusValid,
  output logic [LEN_W-1:0] statusLength,
  output logic [LEN_W-1:0] statusPayload,
  output logic             statusRunt,
  output logic             statusOversize,
  output logic             statusJumbo,
  output logic             statusShortGap,
  output logic [CNT_W-1:0] runtCount,
  output logic [CNT_W-1:0] oversizeCount,
  output logic [CNT_W-1:0] shortGapCount
);

  mon_strobe_t          strobe;
  logic [ERR_KINDS-1:0] errHit;
  logic [CNT_W-1:0]     errCount [ERR_KINDS];

  frmon_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxDv     (rxDv),
    .rxByteEn (rxByteEn),
    .rxData   (rxData),
    .strobe   (strobe)
  );

  frmon_datapath #(
    .LEN_W     (LEN_W),
    .JUMBO_MAX (JUMBO_MAX),
    .GAP_BITS  (GAP_BITS),
    .CPB_100M  (CPB_100M),
    .CPB_10M   (CPB_10M)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe         (strobe),
    .linkSpeed      (linkSpeed),
    .jumboEn        (jumboEn),
    .statusValid    (statusValid),
    .statusLength   (statusLength),
    .statusPayload  (statusPayload),
    .statusRunt     (statusRunt),
    .statusOversize (statusOversize),
    .statusJumbo    (statusJumbo),
    .statusShortGap (statusShortGap)
  );

  assign errHit = {ERR_KINDS{statusValid}} & {statusShortGap, statusOversize, statusRunt};

  for (genvar g = 0; g < ERR_KINDS; g++) begin : g_err
    frmon_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clrCounters),
      .inc   (errHit[g]),
      .count (errCount[g])
    );
  end

  assign runtCount     = errCount[0];
  assign oversizeCount = errCount[1];
  assign shortGapCount = errCount[2];

endmodule

// File: tb/frame_gap_monitor_tb.sv
module frame_gap_monitor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 16;
  localparam int CNT_W      = 8;
  localparam int JMAX       = 9000;
  localparam int CNT_TOP    = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rxDv = 1'b0;
  logic             rxByteEn = 1'b0;
  logic [7:0]       rxData = 8'h00;
  logic [1:0]       linkSpeed = 2'b10;
  logic             jumboEn = 1'b0;
  logic             clrCounters = 1'b0;
  logic             statusValid;
  logic [LEN_W-1:0] statusLength;
  logic [LEN_W-1:0] statusPayload;
  logic             statusRunt;
  logic             statusOversize;
  logic             statusJumbo;
  logic             statusShortGap;
  logic [CNT_W-1:0] runtCount;
  logic [CNT_W-1:0] oversizeCount;
  logic [CNT_W-1:0] shortGapCount;

  int  nChecks = 0;
  int  nBad = 0;
  bit  armedM = 1'b0;
  int  runtM = 0;
  int  overM = 0;
  int  shortM = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_gap_monitor #(
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W),
    .JUMBO_MAX (JMAX)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rxDv           (rxDv),
    .rxByteEn       (rxByteEn),
    .rxData         (rxData),
    .linkSpeed      (linkSpeed),
    .jumboEn        (jumboEn),
    .clrCounters    (clrCounters),
    .statusValid    (statusValid),
    .statusLength   (statusLength),
    .statusPayload  (statusPayload),
    .statusRunt     (statusRunt),
    .statusOversize (statusOversize),
    .statusJumbo    (statusJumbo),
    .statusShortGap (statusShortGap),
    .runtCount      (runtCount),
    .oversizeCount  (oversizeCount),
    .shortGapCount  (shortGapCount)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gapLimit(input logic [1:0] spd);
    case (spd)
      2'b00:   return 1200;
      2'b01:   return 120;
      default: return 12;
    endcase
  endfunction

  function automatic int satInc(input int v, input bit hit);
    return (hit && v < CNT_TOP) ? v + 1 : v;
  endfunction

  task automatic sendByte(input logic [7:0] b, input int stride);
    for (int k = 1; k < stride; k++) begin
      @(negedge clk); rxDv = 1'b1; rxByteEn = 1'b0; rxData = 8'hD5;  // R11 idle-enable clocks
    end
    @(negedge clk); rxDv = 1'b1; rxByteEn = 1'b1; rxData = b;
  endtask

  // Sends one frame preceded by a gap of exactly 'gap' low edges since the last frame
  task automatic runFrame(input int n, input int gap, input bit withSfd,
                          input int stride, input bit clrAtStatus);
    int  expLen;
    int  expPay;
    bit  eRunt;
    bit  eOver;
    bit  eJumbo;
    bit  eShort;
    repeat ((gap > 3) ? gap - 3 : 0) @(negedge clk);
    eShort = armedM && (gap < gapLimit(linkSpeed));
    for (int i = 0; i < 7; i++) sendByte(8'h55, stride);
    if (withSfd) sendByte(8'hD5, stride);
    for (int i = 0; i < n; i++) sendByte(withSfd ? i[7:0] : 8'h55, stride);
    @(negedge clk); rxDv = 1'b0; rxByteEn = 1'b0; rxData = 8'h00;
    expLen = withSfd ? n : 0;
    expPay = (expLen >= 18) ? expLen - 18 : 0;
    eRunt  = expLen < 64;
    eOver  = jumboEn ? (expPay > JMAX) : (expPay > 1500);
    eJumbo = jumboEn && (expPay > 1500) && (expPay <= JMAX);
    @(negedge clk);
    chk("R2", "statusValid", statusValid, 1);
    chk("R2", "length", statusLength, expLen);
    chk("R3", "payload", statusPayload, expPay);
    chk("R4", "runt", statusRunt, eRunt);
    chk("R5", "oversize", statusOversize, eOver);
    chk("R6", "jumbo", statusJumbo, eJumbo);
    chk("R7", "shortGap", statusShortGap, eShort);
    clrCounters = clrAtStatus;
    if (clrAtStatus) begin
      runtM = 0; overM = 0; shortM = 0;
    end else begin
      runtM  = satInc(runtM, eRunt);
      overM  = satInc(overM, eOver);
      shortM = satInc(shortM, eShort);
    end
    armedM = 1'b1;
    @(negedge clk);
    clrCounters = 1'b0;
    chk("R2", "strobe one clock", statusValid, 0);
    chk(clrAtStatus ? "R10" : "R9", "runtCount", runtCount, runtM);
    chk(clrAtStatus ? "R10" : "R9", "oversizeCount", oversizeCount, overM);
    chk(clrAtStatus ? "R10" : "R9", "shortGapCount", shortGapCount, shortM);
  endtask

  task automatic clearAll();
    @(negedge clk); clrCounters = 1'b1;
    @(negedge clk); clrCounters = 1'b0;
    runtM = 0; overM = 0; shortM = 0;
    chk("R10", "runtCount after clear", runtCount, 0);
    chk("R10", "oversizeCount after clear", oversizeCount, 0);
    chk("R10", "shortGapCount after clear", shortGapCount, 0);
  endtask

  task automatic scResetAndFirst();
    repeat (4) @(negedge clk);
    chk("R1", "statusValid in reset", statusValid, 0);
    chk("R1", "runtCount in reset", runtCount, 0);
    @(negedge clk); rst_n = 1'b1;
    chk("R1", "statusRunt after reset", statusRunt, 0);
    chk("R1", "shortGap after reset", statusShortGap, 0);
    chk("R1", "shortGapCount after reset", shortGapCount, 0);
    // R8: frame starts one idle clock after reset, exempt from the gap rule
    runFrame(64, 3, 1'b1, 1, 1'b0);
  endtask

  task automatic scLengths();
    runFrame(63, 12, 1'b1, 1, 1'b0);   // R4 boundary
    runFrame(10, 12, 1'b1, 1, 1'b0);   // R3 floor at 0
    runFrame(5, 12, 1'b0, 1, 1'b0);    // R4 no delimiter
  endtask

  task automatic scGapFast();
    runFrame(64, 11, 1'b1, 1, 1'b0);   // R7 short
    runFrame(64, 12, 1'b1, 1, 1'b0);   // R7 exact limit
  endtask

  task automatic scOversize();
    runFrame(1518, 12, 1'b1, 1, 1'b0); // R5 payload 1500
    runFrame(1519, 12, 1'b1, 1, 1'b0); // R5 payload 1501
  endtask

  task automatic scJumbo();
    jumboEn = 1'b1;
    runFrame(1519, 12, 1'b1, 1, 1'b0);
    runFrame(JMAX + 18, 12, 1'b1, 1, 1'b0);
    runFrame(JMAX + 19, 12, 1'b1, 1, 1'b0);
    jumboEn = 1'b0;
  endtask

  task automatic scSpeeds();
    linkSpeed = 2'b01;
    runFrame(64, 119, 1'b1, 1, 1'b0);
    runFrame(64, 120, 1'b1, 1, 1'b0);
    linkSpeed = 2'b00;
    runFrame(64, 1199, 1'b1, 1, 1'b0);
    runFrame(64, 1200, 1'b1, 1, 1'b0);
    linkSpeed = 2'b11;
    runFrame(64, 11, 1'b1, 1, 1'b0);
    linkSpeed = 2'b10;
  endtask

  task automatic scByteEnable();
    runFrame(64, 12, 1'b1, 3, 1'b0);   // R11
    runFrame(63, 12, 1'b1, 4, 1'b0);   // R11 with runt
  endtask

  task automatic scClearCollision();
    clearAll();
    runFrame(20, 30, 1'b1, 1, 1'b0);
    runFrame(20, 30, 1'b1, 1, 1'b1);   // R10 clear meets increment
    runFrame(20, 30, 1'b1, 1, 1'b0);
  endtask

  task automatic scSaturate();
    clearAll();
    for (int i = 0; i < CNT_TOP + 5; i++) runFrame(8, 3, 1'b1, 1, 1'b0);  // R9
    chk("R9", "runt saturated", runtCount, CNT_TOP);
    chk("R9", "shortGap saturated", shortGapCount, CNT_TOP);
  endtask

  initial begin
    scResetAndFirst();
    scLengths();
    scGapFast();
    scOversize();
    scJumbo();
    scSpeeds();
    scByteEnable();
    scClearCollision();
    scSaturate();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule